// File: doc/BRIEF.md
# DRAM Initialization and Refresh Sequencer

This block lives inside a controller for an asynchronous extended-data-out DRAM with a 4-bit data path. It owns the row and column strobes for refresh traffic. After reset it keeps both strobes high for a power-up pause. It then runs a fixed warm-up series of CAS-before-RAS refresh cycles and raises `ready`. From then on an interval timer adds one owed refresh per refresh period. Owed refreshes are served between host accesses, which are granted through a request/grant handshake. While a grant is held, the host's own access logic drives the DRAM pins.

The block also handles self refresh. When `sr_req` is seen, it first runs the bracketing refreshes: one refresh in distributed mode, or a full burst in burst mode. It then starts a CAS-before-RAS cycle and keeps RAS low for as long as `sr_req` stays high. On exit it measures how long RAS was low and picks the long self-refresh precharge or the normal one. It then runs the bracketing refreshes again and returns to normal scheduling with the interval timer restarted. All intervals are given in nanoseconds and turned into clock counts using a clock-period parameter. If owed refreshes pile up beyond a limit, an error flag is raised.

Top module: `dram_refresh_sequencer`

## Requirements
- R1: From reset, `ras_n` and `cas_n` are high, and `ready` and `host_gnt` are low. After reset is released this state holds for exactly ceil(PWRUP_NS*1000/CLK_PS) cycles.
- R2: After the pause, exactly WARM_CNT refresh cycles run back to back. `ready` rises in the cycle after the last one completes and never falls again until reset.
- R3: Each refresh cycle has four parts: one cycle with both strobes high, then the CSR cycles with only `cas_n` low, then the RAS cycles with both low, then a precharge with both high. `ras_n` never falls unless `cas_n` was already low in the cycle before.
- R4: While `ready` is high and no self-refresh sequence is running, every INTERVAL cycles add one owed refresh. Each owed refresh is served as one refresh cycle whenever no grant is held.
- R5: With nothing owed and no self-refresh request, a `host_req` seen in an idle cycle gives `host_gnt` high from the next cycle. The grant stays high while `host_req` stays high and drops one cycle after `host_req` is seen low. No refresh strobe moves while a grant is held.
- R6: `debt_err` is high exactly while the number of owed refreshes exceeds DEBT_LIMIT.
- R7: An `sr_req` seen in an idle cycle first runs the bracketing refreshes: 1 when `burst_mode`=0, BURST_CNT when `burst_mode`=1. Then comes one cycle with both strobes high, then a CAS-before-RAS entry. RAS stays low for at least the RAS cycles and for as long as `sr_req` stays high. `sr_active` is high from the entry's first `cas_n`-low cycle to the end of its precharge.
- R8: The precharge after the self-refresh RAS-low period lasts RPS cycles if RAS was low for at least LONG cycles, and RP cycles otherwise.
- R9: After the self-refresh precharge, the bracketing refreshes run again (count chosen by `burst_mode` at that moment). The block then returns to idle with no debt and a fresh interval.
- R10: In an idle cycle the choice is made in this order: a self-refresh request first, then an owed refresh, then a host request. A grant that is already held is never cut short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host asks for the DRAM; hold high for the whole access |
| sr_req | input | 1 | High requests self refresh; low requests exit |
| burst_mode | input | 1 | Bracketing style: 0 distributed (one refresh), 1 burst |
| host_gnt | output | 1 | Host owns the DRAM pins |
| ras_n | output | 1 | Row strobe for refresh, active low |
| cas_n | output | 1 | Column strobe for refresh, active low |
| ready | output | 1 | Pause and warm-up finished |
| sr_active | output | 1 | Self-refresh entry, hold or exit precharge in progress |
| debt_err | output | 1 | Owed refreshes exceed the limit |

## Verification
The assertions assume that the host keeps `host_req` high until it has seen the grant and finished its access, and that it never drops the request and raises it again in the same cycle. They also assume that `burst_mode` changes only while the block is idle and not in a self-refresh sequence. The stimulus changes every input on the falling clock edge. It changes `burst_mode` only during long idle stretches, long after any self-refresh sequence has finished. It lowers `sr_req` only after raising it for a fixed window, which covers both a short and a long self-refresh period.

// File: rtl/dram_seq_pkg.sv
`timescale 1ns/1ps
package dram_seq_pkg;

  // Top-level sequencing phases
  typedef enum logic [3:0] {
    ST_PWR,       // power-up pause, strobes quiet
    ST_WARM,      // warm-up refresh series
    ST_IDLE,      // ready, choosing the next job
    ST_HOST,      // host owns the pins
    ST_REF,       // one owed refresh
    ST_PRE_SR,    // bracketing refreshes before self refresh
    ST_SR_ENTER,  // launch the self-refresh CBR cycle
    ST_SR_HOLD,   // RAS held low, then exit precharge
    ST_POST_SR    // bracketing refreshes after self refresh
  } seq_state_e;

  // Strobe engine phases
  typedef enum logic [2:0] {
    EN_IDLE,
    EN_CSU,   // CAS low, RAS still high
    EN_RAS,   // both low, minimum RAS time
    EN_HOLD,  // both low, self refresh hold
    EN_PRE    // both high, precharge
  } eng_state_e;

  // Round a nanosecond interval up to whole clock cycles, never below one
  function automatic int ns_to_cycles(input longint ns, input longint clk_ps);
    longint c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Bits needed to hold the value n
  function automatic int bits_for(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/cbr_engine.sv
`timescale 1ns/1ps
module cbr_engine
  import dram_seq_pkg::*;
#(
  parameter int CSR_CYC  = 2,
  parameter int RAS_CYC  = 10,
  parameter int RP_CYC   = 6,
  parameter int RPS_CYC  = 18,
  parameter int LONG_CYC = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic hold,
  output logic ras_n,
  output logic cas_n,
  output logic idle,
  output logic done,
  output logic long_low
);

  localparam int TMAX = max2(max2(CSR_CYC, RAS_CYC), max2(RP_CYC, RPS_CYC));
  localparam int TW   = bits_for(TMAX);
  localparam int LW   = bits_for(LONG_CYC);

  eng_state_e     state;
  logic [TW-1:0]  cnt;
  logic [LW-1:0]  lcnt;     // RAS-low cycles so far, saturating
  logic [TW-1:0]  pre_load;
  logic           long_now;

  // lcnt is one behind the cycle count, so compare against LONG-1
  assign long_now = (lcnt >= LW'(LONG_CYC - 1));
  assign pre_load = long_now ? TW'(RPS_CYC - 1) : TW'(RP_CYC - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= EN_IDLE;
      cnt   <= '0;
      lcnt  <= '0;
    end else begin
      case (state)
        EN_IDLE: begin
          if (start) begin
            state <= EN_CSU;
            cnt   <= TW'(CSR_CYC - 1);
          end
        end
        EN_CSU: begin
          if (cnt == '0) begin
            state <= EN_RAS;
            cnt   <= TW'(RAS_CYC - 1);
            lcnt  <= '0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        EN_RAS: begin
          if (!long_now) lcnt <= lcnt + 1'b1;
          if (cnt == '0) begin
            if (hold) begin
              state <= EN_HOLD;
            end else begin
              state <= EN_PRE;
              cnt   <= pre_load;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        EN_HOLD: begin
          if (!long_now) lcnt <= lcnt + 1'b1;
          if (!hold) begin
            state <= EN_PRE;
            cnt   <= pre_load;
          end
        end
        EN_PRE: begin
          if (cnt == '0) state <= EN_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= EN_IDLE;
      endcase
    end
  end

  assign cas_n    = !(state == EN_CSU || state == EN_RAS || state == EN_HOLD);
  assign ras_n    = !(state == EN_RAS || state == EN_HOLD);
  assign idle     = (state == EN_IDLE);
  assign done     = (state == EN_PRE) && (cnt == '0);
  assign long_low = long_now && !ras_n;

endmodule

// File: rtl/refresh_debt.sv
`timescale 1ns/1ps
module refresh_debt
  import dram_seq_pkg::*;
#(
  parameter int INT_CYC    = 3120,
  parameter int DEBT_LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,     // low clears timer and debt
  input  logic dec,    // one owed refresh completed
  output logic owed,
  output logic err
);

  localparam int TW   = bits_for(INT_CYC);
  localparam int DW   = bits_for(DEBT_LIMIT + 1) + 1;
  localparam int DMAX = (1 << DW) - 1;

  logic [TW-1:0] tcnt;
  logic [DW-1:0] debt;
  logic [DW-1:0] debt_nx;
  logic          tick;

  assign tick = en && (tcnt == TW'(INT_CYC - 1));

  always_comb begin
    debt_nx = debt;
    if (tick && !dec) begin
      if (debt != DW'(DMAX)) debt_nx = debt + 1'b1;
    end else if (dec && !tick) begin
      if (debt != '0) debt_nx = debt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0;
      debt <= '0;
    end else if (!en) begin
      tcnt <= '0;
      debt <= '0;
    end else begin
      tcnt <= tick ? '0 : tcnt + 1'b1;
      debt <= debt_nx;
    end
  end

  assign owed = (debt != '0);
  assign err  = (debt > DW'(DEBT_LIMIT));

endmodule

// File: rtl/dram_refresh_sequencer.sv
`timescale 1ns/1ps
module dram_refresh_sequencer
  import dram_seq_pkg::*;
#(
  parameter int CLK_PS      = 5000,
  parameter int PWRUP_NS    = 200000,
  parameter int WARM_CNT    = 8,
  parameter int INTERVAL_NS = 15600,
  parameter int BURST_CNT   = 2048,
  parameter int LONG_SR_NS  = 100000,
  parameter int T_CSR_NS    = 10,
  parameter int T_RAS_NS    = 50,
  parameter int T_RP_NS     = 30,
  parameter int T_RPS_NS    = 90,
  parameter int DEBT_LIMIT  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_req,
  input  logic sr_req,
  input  logic burst_mode,
  output logic host_gnt,
  output logic ras_n,
  output logic cas_n,
  output logic ready,
  output logic sr_active,
  output logic debt_err
);

  localparam int PWR_CYC  = ns_to_cycles(PWRUP_NS, CLK_PS);
  localparam int INT_CYC  = ns_to_cycles(INTERVAL_NS, CLK_PS);
  localparam int LONG_CYC = ns_to_cycles(LONG_SR_NS, CLK_PS);
  localparam int CSR_CYC  = ns_to_cycles(T_CSR_NS, CLK_PS);
  localparam int RAS_CYC  = ns_to_cycles(T_RAS_NS, CLK_PS);
  localparam int RP_CYC   = ns_to_cycles(T_RP_NS, CLK_PS);
  localparam int RPS_CYC  = ns_to_cycles(T_RPS_NS, CLK_PS);
  localparam int PW       = bits_for(PWR_CYC);
  localparam int RW       = bits_for(max2(WARM_CNT, BURST_CNT));

  seq_state_e    state;
  logic [PW-1:0] pwr_cnt;
  logic [RW-1:0] rem;          // refreshes left in the running series

  // Named internal events
  logic series_w;               // a counted refresh series is running
  logic eng_start, eng_hold, eng_idle, eng_done, eng_long;
  logic timer_en, ref_done_w, owed_w;
  logic pause_w;
  logic [RW-1:0] bracket_n;

  assign series_w   = (state == ST_WARM) || (state == ST_REF) ||
                      (state == ST_PRE_SR) || (state == ST_POST_SR);
  assign eng_start  = eng_idle && (series_w || state == ST_SR_ENTER);
  assign eng_hold   = sr_req && (state == ST_SR_HOLD);
  assign timer_en   = (state == ST_IDLE) || (state == ST_HOST) || (state == ST_REF);
  assign ref_done_w = eng_done && (state == ST_REF);
  assign pause_w    = (state == ST_PWR);
  assign bracket_n  = burst_mode ? RW'(BURST_CNT) : RW'(1);

  cbr_engine #(
    .CSR_CYC (CSR_CYC),
    .RAS_CYC (RAS_CYC),
    .RP_CYC  (RP_CYC),
    .RPS_CYC (RPS_CYC),
    .LONG_CYC(LONG_CYC)
  ) eng_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (eng_start),
    .hold    (eng_hold),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .idle    (eng_idle),
    .done    (eng_done),
    .long_low(eng_long)
  );

  refresh_debt #(
    .INT_CYC   (INT_CYC),
    .DEBT_LIMIT(DEBT_LIMIT)
  ) debt_i (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (timer_en),
    .dec  (ref_done_w),
    .owed (owed_w),
    .err  (debt_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_PWR;
      pwr_cnt <= PW'(PWR_CYC - 1);
      rem     <= '0;
    end else begin
      case (state)
        ST_PWR: begin
          if (pwr_cnt == '0) begin
            state <= ST_WARM;
            rem   <= RW'(WARM_CNT);
          end else begin
            pwr_cnt <= pwr_cnt - 1'b1;
          end
        end
        ST_WARM: begin
          if (eng_done) begin
            if (rem == RW'(1)) state <= ST_IDLE;
            else               rem   <= rem - 1'b1;
          end
        end
        ST_IDLE: begin
          // priority: self refresh, owed refresh, host
          if (sr_req) begin
            state <= ST_PRE_SR;
            rem   <= bracket_n;
          end else if (owed_w) begin
            state <= ST_REF;
          end else if (host_req) begin
            state <= ST_HOST;
          end
        end
        ST_HOST:  if (!host_req) state <= ST_IDLE;
        ST_REF:   if (eng_done)  state <= ST_IDLE;
        ST_PRE_SR: begin
          if (eng_done) begin
            if (rem == RW'(1)) state <= ST_SR_ENTER;
            else               rem   <= rem - 1'b1;
          end
        end
        ST_SR_ENTER: state <= ST_SR_HOLD;
        ST_SR_HOLD: begin
          if (eng_done) begin
            state <= ST_POST_SR;
            rem   <= bracket_n;
          end
        end
        ST_POST_SR: begin
          if (eng_done) begin
            if (rem == RW'(1)) state <= ST_IDLE;
            else               rem   <= rem - 1'b1;
          end
        end
        default: state <= ST_PWR;
      endcase
    end
  end

  assign host_gnt  = (state == ST_HOST);
  assign ready     = !(state == ST_PWR || state == ST_WARM);
  assign sr_active = (state == ST_SR_HOLD);

endmodule

// File: rtl/dram_refresh_sequencer_chk.sv
`timescale 1ns/1ps
module dram_refresh_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic host_req,
  input logic host_gnt,
  input logic ras_n,
  input logic cas_n,
  input logic ready,
  input logic sr_active,
  input logic debt_err,
  input logic in_pause,
  input logic long_low
);

  AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_pause |-> (ras_n && cas_n && !ready)); // R1

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready); // R2

  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!cas_n)); // R3

  AST_RAS_INSIDE_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n); // R3

  AST_GRANT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    host_gnt |-> (ras_n && cas_n && !sr_active)); // R5

  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_gnt && host_req) |=> host_gnt); // R10

  AST_ERR_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    debt_err |-> ready); // R6

  AST_LONG_ONLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    long_low |-> (!ras_n && ready)); // R8

endmodule

bind dram_refresh_sequencer dram_refresh_sequencer_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .host_req (host_req),
  .host_gnt (host_gnt),
  .ras_n    (ras_n),
  .cas_n    (cas_n),
  .ready    (ready),
  .sr_active(sr_active),
  .debt_err (debt_err),
  .in_pause (pause_w),
  .long_low (eng_long)
);

// File: tb/dram_refresh_sequencer_tb_top.sv
`timescale 1ns/1ps
module dram_refresh_sequencer_tb_top;

  // Bench-side timing, 5 ns clock
  localparam int PWR   = 1000 / 5;
  localparam int INTV  = 500 / 5;
  localparam int LONG  = 300 / 5;
  localparam int CSR   = 10 / 5;
  localparam int RAS   = 50 / 5;
  localparam int RP    = 30 / 5;
  localparam int RPS   = 90 / 5;
  localparam int WARM  = 8;
  localparam int BURST = 4;
  localparam int LIM   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_req = 1'b0;
  logic sr_req = 1'b0;
  logic burst_mode = 1'b0;
  logic host_gnt, ras_n, cas_n, ready, sr_active, debt_err;

  always #2.5 clk = ~clk;

  dram_refresh_sequencer #(
    .CLK_PS(5000), .PWRUP_NS(1000), .WARM_CNT(WARM), .INTERVAL_NS(500),
    .BURST_CNT(BURST), .LONG_SR_NS(300), .T_CSR_NS(10), .T_RAS_NS(50),
    .T_RP_NS(30), .T_RPS_NS(90), .DEBT_LIMIT(LIM)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .sr_req(sr_req),
    .burst_mode(burst_mode), .host_gnt(host_gnt), .ras_n(ras_n),
    .cas_n(cas_n), .ready(ready), .sr_active(sr_active), .debt_err(debt_err)
  );

  int checks = 0;
  int failures = 0;
  bit ended = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  string ph = "R1";
  bit e_ras = 1, e_cas = 1, e_gnt = 0, e_rdy = 0, e_sr = 0, e_err = 0;
  int debt = 0, tcnt = 0;
  bit s_sr, s_host, s_burst, s_owed;
  int long_seen = 0, short_seen = 0;

  // One clock of expected behaviour; samples inputs at the closing edge
  task automatic cyc(input bit r, input bit c, input bit en, input bit dec);
    e_ras = r; e_cas = c; e_err = (debt > LIM);
    @(posedge clk);
    s_sr = sr_req; s_host = host_req; s_burst = burst_mode; s_owed = (debt != 0);
    if (!en) begin
      tcnt = 0; debt = 0;
    end else begin
      tcnt++;
      if (tcnt == INTV) begin tcnt = 0; debt++; end
      if (dec) debt--;
    end
    #1;
  endtask

  task automatic refresh(input bit en, input bit dec_last, input string tag);
    ph = tag;
    cyc(1, 1, en, 0);
    ph = "R3";
    repeat (CSR) cyc(1, 0, en, 0);
    repeat (RAS) cyc(0, 0, en, 0);
    ph = tag;
    for (int i = 0; i < RP; i++) cyc(1, 1, en, dec_last && (i == RP - 1));
  endtask

  task automatic self_refresh();
    int low;
    int pre;
    ph = "R7";
    e_sr = 0;
    cyc(1, 1, 0, 0);
    e_sr = 1;
    repeat (CSR) cyc(1, 0, 0, 0);
    low = 0;
    repeat (RAS) begin cyc(0, 0, 0, 0); low++; end
    while (s_sr) begin cyc(0, 0, 0, 0); low++; end
    pre = (low >= LONG) ? RPS : RP;
    if (low >= LONG) long_seen++; else short_seen++;
    ph = "R8";
    repeat (pre) cyc(1, 1, 0, 0);
    e_sr = 0;
  endtask

  initial begin : model
    int n;
    @(posedge rst_n);
    ph = "R1";
    repeat (PWR) cyc(1, 1, 0, 0);
    repeat (WARM) refresh(0, 0, "R2");
    e_rdy = 1;
    forever begin
      ph = "R4";
      e_gnt = 0;
      cyc(1, 1, 1, 0);
      if (s_sr) begin
        n = s_burst ? BURST : 1;
        repeat (n) refresh(0, 0, "R7");
        self_refresh();
        n = s_burst ? BURST : 1;
        repeat (n) refresh(0, 0, "R9");
      end else if (s_owed) begin
        refresh(1, 1, s_host ? "R10" : "R4");
      end else if (s_host) begin
        ph = "R5";
        e_gnt = 1;
        do cyc(1, 1, 1, 0); while (s_host);
        e_gnt = 0;
      end
    end
  end

  // Compare every clock away from the active edge
  always @(negedge clk) begin
    if (!ended) begin
      check(ras_n === e_ras, ph, "ras_n", ras_n, e_ras);
      check(cas_n === e_cas, ph, "cas_n", cas_n, e_cas);
      check(host_gnt === e_gnt, "R5", "host_gnt", host_gnt, e_gnt);
      check(ready === e_rdy, "R2", "ready", ready, e_rdy);
      check(sr_active === e_sr, "R7", "sr_active", sr_active, e_sr);
      check(debt_err === e_err, "R6", "debt_err", debt_err, e_err);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : stim
    bit err_seen;
    wait_n(5);
    check(ras_n && cas_n && !ready && !host_gnt, "R1", "reset strobes/ready", {ras_n, cas_n, ready}, 3'b110);
    rst_n = 1'b1;
    while (!ready) @(negedge clk);
    wait_n(30);
    host_req = 1'b1; wait_n(40); host_req = 1'b0;        // R5 short access
    wait_n(150);                                          // R4 owed refresh in idle
    host_req = 1'b1;                                      // R6 long access builds debt
    err_seen = 1'b0;
    for (int i = 0; i < 350; i++) begin
      @(negedge clk);
      if (debt_err) err_seen = 1'b1;
    end
    host_req = 1'b0;
    check(err_seen, "R6", "debt_err raised during long grant", err_seen, 1);
    wait_n(2);
    host_req = 1'b1; wait_n(10); host_req = 1'b0;        // R10 host behind owed refreshes
    wait_n(200);
    sr_req = 1'b1; wait_n(60); sr_req = 1'b0;            // R7 R8 short, distributed
    wait_n(100);
    sr_req = 1'b1; wait_n(150); sr_req = 1'b0;           // R8 long hold
    wait_n(100);
    burst_mode = 1'b1;
    wait_n(20);
    sr_req = 1'b1; wait_n(120); sr_req = 1'b0;           // R9 burst bracketing
    wait_n(250);
    host_req = 1'b1; wait_n(20); host_req = 1'b0;
    wait_n(100);
    check(long_seen == 1, "R8", "long self-refresh periods", long_seen, 1);
    check(short_seen == 2, "R8", "short self-refresh periods", short_seen, 2);
    check(ready, "R2", "ready at end", ready, 1);
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (60000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule